// File: doc/BRIEF.md
# FIFO-fed programmable CRC engine

The block computes a cyclic redundancy check of any length from 1 to 32 bits over a stream of data words. Words are pushed into a small internal word queue. While the start control is held high, a serializer takes one word at a time from the queue and feeds it, one bit per clock, into a Galois-form linear feedback shift register. The feedback polynomial, the register length and the starting remainder (seed) all come from configuration inputs.

Status outputs give the number of queued words and full and empty flags. The queue holds 16 words for short polynomials and 8 words for polynomials longer than 8 bits. The bit order of each word is selectable. A one-cycle interrupt pulse fires at one of two points: when the queue runs dry while the last word is still shifting, or when the whole run has finished and the remainder is final. Dropping the enable returns the queue, the serializer, the remainder and the flags to their empty state. The configuration inputs are left alone.

Top module: `crc_fifo_engine`

## Requirements
- R1: After reset, and on the clock after `enable` is low, the queue is empty (`word_count`=0, `fifo_empty`=1, `fifo_full`=0), `result_valid`=0, `irq`=0 and `result`=0.
- R2: `word_count` equals the number of words accepted and not yet taken by the serializer. `fifo_empty` is 1 exactly when it is 0, and `fifo_full` is 1 when it has reached the capacity.
- R3: The capacity is 16 words when `poly_len_m1` <= 7 and 8 words when `poly_len_m1` > 7. A write presented while `fifo_full`=1 is dropped and never reaches the CRC.
- R4: While running, the serializer spends one clock taking a word from the queue, then shifts `word_len_m1`+1 bits at one bit per clock. A run of K words of N bits finishes on the K*(N+1)-th rising edge counted from the first edge with `start` high.
- R5: For each bit d, with L = `poly_len_m1`: f = d XOR rem[L]; then rem = ((rem << 1) XOR (f ? `poly` : 0)), keeping bits L..0. A `seed_load` pulse while enabled sets rem to `seed` masked to L+1 bits. `result` shows rem masked to L+1 bits.
- R6: With `bit_order`=1 a word is shifted starting from bit 0 and moving up. With `bit_order`=0 it starts from bit `word_len_m1` and moves down. Bits above `word_len_m1` are never used.
- R7: With `irq_sel`=1, `irq` is high for one clock, starting on the edge at which the serializer takes the last queued word.
- R8: With `irq_sel`=0, `irq` is high for one clock, starting on the edge that shifts the final bit while the queue is empty. `result_valid` rises on that same edge.
- R9: While `start` is low, no word is taken and no bit is shifted. Raising `start` again continues the run where it stopped.
- R10: With `stop_in_idle`=1, a high `idle` halts the serializer just as a low `start` does. With `stop_in_idle`=0, `idle` has no effect on progress.
- R11: `result_valid` stays high, with `result` unchanged, until an accepted write, a `seed_load` or a low `enable`. Each of these clears it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released through a two-stage synchronizer |
| enable | input | 1 | Module enable; low clears all run state |
| start | input | 1 | Serializer runs while high |
| stop_in_idle | input | 1 | 1 = halt while `idle` is high |
| idle | input | 1 | System idle indication |
| bit_order | input | 1 | 1 = bit 0 first, 0 = top bit first |
| irq_sel | input | 1 | 1 = pulse on queue drained, 0 = pulse on run finished |
| poly_len_m1 | input | 5 | Polynomial length minus one |
| word_len_m1 | input | 5 | Data word length minus one |
| poly | input | 32 | Feedback taps (bit L set implicitly by the top term) |
| seed | input | 32 | Starting remainder |
| seed_load | input | 1 | Load `seed` into the remainder |
| wr_valid | input | 1 | Push `wr_data` into the queue |
| wr_data | input | 32 | Data word |
| word_count | output | 5 | Words currently queued |
| fifo_full | output | 1 | Queue at capacity |
| fifo_empty | output | 1 | Queue holds no word |
| irq | output | 1 | One-cycle interrupt pulse |
| result | output | 32 | Current remainder, masked to the polynomial length |
| result_valid | output | 1 | Run finished, `result` final |

## Verification
Queue status registers on the clock edge that accepts a write. The drained-queue interrupt appears on the edge that takes the last word, which is edge (K-1)*(N+1) counted from zero at the first edge with `start` high. The finish interrupt and `result_valid` appear on edge K*(N+1)-1, and a halt of H clocks pushes both later by H. The bench drives every input on a falling edge and counts falling edges from the first edge with `start` high. It compares the count at which `irq` and `result_valid` first appear with these formulas, and compares `result` against the arithmetic remainder at the first falling edge where `result_valid` is high.

// File: rtl/crc_fifo_pkg.sv
package crc_fifo_pkg;

  typedef enum logic {
    ORDER_MSB_FIRST = 1'b0,
    ORDER_LSB_FIRST = 1'b1
  } bit_order_e;

  typedef enum logic {
    IRQ_AT_DONE  = 1'b0,
    IRQ_AT_EMPTY = 1'b1
  } irq_point_e;

  // Polynomial lengths (minus one) up to this value use the full queue depth.
  localparam int unsigned NARROW_POLY_MAX_M1 = 7;

endpackage

// File: rtl/crc_word_fifo.sv
// Word queue with a capacity of DEPTH or DEPTH/2, chosen at run time.
// DEPTH must be a power of two.
module crc_word_fifo #(
  parameter  int unsigned WIDTH = 32,
  parameter  int unsigned DEPTH = 16,
  localparam int unsigned AW    = $clog2(DEPTH),
  localparam int unsigned CW    = AW + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             cap_small,
  input  logic             push,
  input  logic [WIDTH-1:0] wdata,
  input  logic             pop,
  output logic [WIDTH-1:0] rdata,
  output logic [CW-1:0]    count,
  output logic             full,
  output logic             empty,
  output logic             push_ok
);

  localparam logic [CW-1:0] CAP_WHOLE = CW'(DEPTH);
  localparam logic [CW-1:0] CAP_HALF  = CW'(DEPTH / 2);

  logic [WIDTH-1:0] mem [DEPTH];
  logic [AW-1:0]    wptr_q, wptr_d;
  logic [AW-1:0]    rptr_q, rptr_d;
  logic [CW-1:0]    cnt_q, cnt_d;
  logic [CW-1:0]    cap;
  logic             pop_ok;

  assign cap     = cap_small ? CAP_HALF : CAP_WHOLE;
  assign full    = (cnt_q >= cap);
  assign empty   = (cnt_q == '0);
  assign push_ok = push & ~full;
  assign pop_ok  = pop & ~empty;
  assign rdata   = mem[rptr_q];
  assign count   = cnt_q;

  always_comb begin
    wptr_d = wptr_q;
    rptr_d = rptr_q;
    cnt_d  = cnt_q;
    if (clr) begin
      wptr_d = '0;
      rptr_d = '0;
      cnt_d  = '0;
    end else begin
      if (push_ok) wptr_d = wptr_q + AW'(1);
      if (pop_ok)  rptr_d = rptr_q + AW'(1);
      case ({push_ok, pop_ok})
        2'b10:   cnt_d = cnt_q + CW'(1);
        2'b01:   cnt_d = cnt_q - CW'(1);
        default: cnt_d = cnt_q;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wptr_q <= '0;
      rptr_q <= '0;
      cnt_q  <= '0;
    end else begin
      wptr_q <= wptr_d;
      rptr_q <= rptr_d;
      cnt_q  <= cnt_d;
    end
  end

  // Storage carries no reset; the count marks which entries are meaningful.
  always_ff @(posedge clk) begin
    if (push_ok) mem[wptr_q] <= wdata;
  end

endmodule

// File: rtl/crc_bit_serializer.sv
// Takes one word per fetch cycle, then presents one bit per clock.
module crc_bit_serializer #(
  parameter  int unsigned DATA_W = 32,
  localparam int unsigned LW     = $clog2(DATA_W),
  localparam int unsigned BW     = LW + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              run,
  input  logic              src_empty,
  input  logic [DATA_W-1:0] src_word,
  input  logic [LW-1:0]     len_m1,
  input  logic              lsb_first,
  output logic              pop,
  output logic              bit_vld,
  output logic              bit_out,
  output logic              last_bit
);

  logic [DATA_W-1:0] sh_q, sh_d;
  logic [BW-1:0]     left_q, left_d;
  logic              busy;

  assign busy     = (left_q != '0);
  assign pop      = run & ~busy & ~src_empty;
  assign bit_vld  = run & busy;
  assign bit_out  = lsb_first ? sh_q[0] : sh_q[len_m1];
  assign last_bit = bit_vld & (left_q == BW'(1));

  always_comb begin
    sh_d   = sh_q;
    left_d = left_q;
    if (clr) begin
      sh_d   = '0;
      left_d = '0;
    end else if (pop) begin
      sh_d   = src_word;
      left_d = BW'(len_m1) + BW'(1);
    end else if (bit_vld) begin
      sh_d   = lsb_first ? (sh_q >> 1) : (sh_q << 1);
      left_d = left_q - BW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q   <= '0;
      left_q <= '0;
    end else begin
      sh_q   <= sh_d;
      left_q <= left_d;
    end
  end

endmodule

// File: rtl/crc_galois_lfsr.sv
// Galois-form remainder register of run-time length len_m1+1.
module crc_galois_lfsr #(
  parameter  int unsigned CRC_W = 32,
  localparam int unsigned LW    = $clog2(CRC_W)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             load,
  input  logic [CRC_W-1:0] seed,
  input  logic [CRC_W-1:0] poly,
  input  logic [LW-1:0]    len_m1,
  input  logic             step,
  input  logic             din,
  output logic [CRC_W-1:0] rem
);

  localparam logic [CRC_W-1:0] ONES_ABOVE_LSB = {{(CRC_W-1){1'b1}}, 1'b0};

  logic [CRC_W-1:0] rem_q, rem_d;
  logic [CRC_W-1:0] mask;
  logic [CRC_W-1:0] advanced;
  logic             fb;

  assign mask     = ~(ONES_ABOVE_LSB << len_m1);
  assign fb       = din ^ rem_q[len_m1];
  assign advanced = {rem_q[CRC_W-2:0], 1'b0} ^ (fb ? poly : '0);
  assign rem      = rem_q & mask;

  always_comb begin
    rem_d = rem_q;
    if (clr)       rem_d = '0;
    else if (load) rem_d = seed & mask;
    else if (step) rem_d = advanced & mask;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rem_q <= '0;
    else        rem_q <= rem_d;
  end

endmodule

// File: rtl/crc_fifo_engine.sv
module crc_fifo_engine #(
  parameter  int unsigned CRC_W      = 32,
  parameter  int unsigned DATA_W     = 32,
  parameter  int unsigned FIFO_DEPTH = 16,
  localparam int unsigned PLW        = $clog2(CRC_W),
  localparam int unsigned DLW        = $clog2(DATA_W),
  localparam int unsigned CW         = $clog2(FIFO_DEPTH) + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              enable,
  input  logic              start,
  input  logic              stop_in_idle,
  input  logic              idle,
  input  logic              bit_order,
  input  logic              irq_sel,
  input  logic [PLW-1:0]    poly_len_m1,
  input  logic [DLW-1:0]    word_len_m1,
  input  logic [CRC_W-1:0]  poly,
  input  logic [CRC_W-1:0]  seed,
  input  logic              seed_load,
  input  logic              wr_valid,
  input  logic [DATA_W-1:0] wr_data,
  output logic [CW-1:0]     word_count,
  output logic              fifo_full,
  output logic              fifo_empty,
  output logic              irq,
  output logic [CRC_W-1:0]  result,
  output logic              result_valid
);

  import crc_fifo_pkg::*;

  logic [1:0]        rst_pipe_q;
  logic              core_rst_n;
  logic              clr, halted, run, cap_small, lsb_first;
  logic              push_ok, pop, bit_vld, bit_out, last_bit;
  logic [DATA_W-1:0] head_word;
  logic              empty_evt, done_evt;
  logic              irq_q, irq_d;
  logic              rv_q, rv_d;
  irq_point_e        irq_point;

  // Reset asserts at once and is released on the second clock edge.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= '0;
    else        rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign core_rst_n = rst_pipe_q[1];

  assign clr       = ~enable;
  assign halted    = stop_in_idle & idle;
  assign run       = enable & start & ~halted & ~seed_load;
  assign cap_small = (poly_len_m1 > PLW'(NARROW_POLY_MAX_M1));
  assign lsb_first = (bit_order_e'(bit_order) == ORDER_LSB_FIRST);
  assign irq_point = irq_point_e'(irq_sel);

  crc_word_fifo #(
    .WIDTH (DATA_W),
    .DEPTH (FIFO_DEPTH)
  ) u_fifo (
    .clk       (clk),
    .rst_n     (core_rst_n),
    .clr       (clr),
    .cap_small (cap_small),
    .push      (enable & wr_valid),
    .wdata     (wr_data),
    .pop       (pop),
    .rdata     (head_word),
    .count     (word_count),
    .full      (fifo_full),
    .empty     (fifo_empty),
    .push_ok   (push_ok)
  );

  crc_bit_serializer #(
    .DATA_W (DATA_W)
  ) u_ser (
    .clk       (clk),
    .rst_n     (core_rst_n),
    .clr       (clr),
    .run       (run),
    .src_empty (fifo_empty),
    .src_word  (head_word),
    .len_m1    (word_len_m1),
    .lsb_first (lsb_first),
    .pop       (pop),
    .bit_vld   (bit_vld),
    .bit_out   (bit_out),
    .last_bit  (last_bit)
  );

  crc_galois_lfsr #(
    .CRC_W (CRC_W)
  ) u_lfsr (
    .clk    (clk),
    .rst_n  (core_rst_n),
    .clr    (clr),
    .load   (enable & seed_load),
    .seed   (seed),
    .poly   (poly),
    .len_m1 (poly_len_m1),
    .step   (bit_vld),
    .din    (bit_out),
    .rem    (result)
  );

  assign empty_evt = pop & (word_count == CW'(1)) & ~push_ok;
  assign done_evt  = last_bit & fifo_empty & ~push_ok;

  always_comb begin
    irq_d = 1'b0;
    rv_d  = rv_q;
    if (clr) begin
      rv_d = 1'b0;
    end else begin
      irq_d = (irq_point == IRQ_AT_EMPTY) ? empty_evt : done_evt;
      if (push_ok || seed_load) rv_d = 1'b0;
      else if (done_evt)        rv_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge core_rst_n) begin
    if (!core_rst_n) begin
      irq_q <= 1'b0;
      rv_q  <= 1'b0;
    end else begin
      irq_q <= irq_d;
      rv_q  <= rv_d;
    end
  end

  assign irq          = irq_q;
  assign result_valid = rv_q;

endmodule

// File: rtl/crc_fifo_engine_chk.sv
module crc_fifo_engine_chk #(
  parameter  int unsigned CRC_W      = 32,
  parameter  int unsigned DATA_W     = 32,
  parameter  int unsigned FIFO_DEPTH = 16,
  localparam int unsigned CW         = $clog2(FIFO_DEPTH) + 1
) (
  input logic             clk,
  input logic             rst_n,
  input logic             enable,
  input logic             start,
  input logic             stop_in_idle,
  input logic             idle,
  input logic             irq_sel,
  input logic             seed_load,
  input logic             wr_valid,
  input logic [CW-1:0]    word_count,
  input logic             fifo_full,
  input logic             fifo_empty,
  input logic             irq,
  input logic [CRC_W-1:0] result,
  input logic             result_valid
);

  p_disable_clears_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> (word_count == '0 && fifo_empty && !fifo_full && !result_valid && !irq && result == '0));

  p_count_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    enable |=> (word_count == $past(word_count) ||
                word_count == $past(word_count) + CW'(1) ||
                word_count + CW'(1) == $past(word_count)));

  p_full_write_dropped_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && wr_valid && fifo_full) |=> (word_count <= $past(word_count)));

  p_count_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
    word_count <= CW'(FIFO_DEPTH));

  p_irq_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
    irq |=> !irq);

  p_done_irq_result_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && !$past(irq_sel)) |-> result_valid);

  p_start_low_halts_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && !start && !wr_valid && !seed_load) |=> ($stable(word_count) && !irq));

  p_idle_halts_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && stop_in_idle && idle && !wr_valid && !seed_load) |=> ($stable(word_count) && !irq));

  p_result_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && result_valid && !wr_valid && !seed_load) |=> result_valid);

endmodule

bind crc_fifo_engine crc_fifo_engine_chk #(
  .CRC_W      (CRC_W),
  .DATA_W     (DATA_W),
  .FIFO_DEPTH (FIFO_DEPTH)
) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .enable       (enable),
  .start        (start),
  .stop_in_idle (stop_in_idle),
  .idle         (idle),
  .irq_sel      (irq_sel),
  .seed_load    (seed_load),
  .wr_valid     (wr_valid),
  .word_count   (word_count),
  .fifo_full    (fifo_full),
  .fifo_empty   (fifo_empty),
  .irq          (irq),
  .result       (result),
  .result_valid (result_valid)
);

// File: tb/crc_fifo_engine_bench.sv
module crc_fifo_engine_bench;

  logic        clk;
  logic        rst_n;
  logic        enable, start, stop_in_idle, idle, bit_order, irq_sel;
  logic [4:0]  poly_len_m1, word_len_m1;
  logic [31:0] poly, seed;
  logic        seed_load, wr_valid;
  logic [31:0] wr_data;
  logic [4:0]  word_count;
  logic        fifo_full, fifo_empty, irq, result_valid;
  logic [31:0] result;

  int total = 0;
  int bad   = 0;
  logic [31:0] job [16];
  logic [31:0] rng = 32'h1234_5678;

  crc_fifo_engine u_crc_fifo_engine (
    .clk(clk), .rst_n(rst_n), .enable(enable), .start(start),
    .stop_in_idle(stop_in_idle), .idle(idle), .bit_order(bit_order),
    .irq_sel(irq_sel), .poly_len_m1(poly_len_m1), .word_len_m1(word_len_m1),
    .poly(poly), .seed(seed), .seed_load(seed_load), .wr_valid(wr_valid),
    .wr_data(wr_data), .word_count(word_count), .fifo_full(fifo_full),
    .fifo_empty(fifo_empty), .irq(irq), .result(result), .result_valid(result_valid)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] next_rnd();
    rng = rng ^ (rng << 13);
    rng = rng ^ (rng >> 17);
    rng = rng ^ (rng << 5);
    return rng;
  endfunction

  // Remainder after k queued words, from the rule stated in R5 and R6.
  function automatic logic [31:0] model_crc(input int k, input int n, input int pl,
                                            input logic ord, input logic [31:0] pol,
                                            input logic [31:0] sd);
    logic [31:0] mask = (pl == 31) ? 32'hFFFF_FFFF : ((32'h1 << (pl + 1)) - 32'h1);
    logic [31:0] rem  = sd & mask;
    for (int w = 0; w < k; w++) begin
      for (int i = 0; i < n; i++) begin
        logic b  = ord ? job[w][i] : job[w][n - 1 - i];
        logic fb = b ^ rem[pl];
        rem = ((rem << 1) ^ (fb ? pol : 32'h0)) & mask;
      end
    end
    return rem;
  endfunction

  task automatic cfg(input int pl, input int dl, input logic ord, input logic sel,
                     input logic [31:0] pol, input logic [31:0] sd);
    poly_len_m1 = 5'(pl);
    word_len_m1 = 5'(dl);
    bit_order   = ord;
    irq_sel     = sel;
    poly        = pol;
    seed        = sd;
  endtask

  task automatic load_seed();
    seed_load = 1'b1;
    @(negedge clk);
    seed_load = 1'b0;
  endtask

  task automatic push(input logic [31:0] w);
    wr_valid = 1'b1;
    wr_data  = w;
    @(negedge clk);
    wr_valid = 1'b0;
  endtask

  // kind: 0 none, 1 start low, 2 idle with stop_in_idle=1, 3 idle with stop_in_idle=0
  task automatic go(input int k, input int pa, input int pl_len, input int kind,
                    output logic [31:0] res);
    int n      = int'(word_len_m1) + 1;
    int extra  = (kind == 1 || kind == 2) ? pl_len : 0;
    int exp_dn = k * (n + 1) - 1 + extra;
    int e_emp  = (k - 1) * (n + 1);
    int exp_ir;
    int c = 0, irq_at = -1, done_at = -1;
    logic [31:0] exp_res = model_crc(k, n, int'(poly_len_m1), bit_order, poly, seed);
    if (kind != 0 && e_emp > pa) e_emp = e_emp + extra;
    exp_ir = irq_sel ? e_emp : exp_dn;
    start = 1'b1;
    while (done_at < 0 && c < 5000) begin
      @(negedge clk);
      if (irq && irq_at < 0) irq_at = c;
      if (result_valid) done_at = c;
      if (kind != 0 && c == pa) begin
        if (kind == 1) start = 1'b0;
        else begin
          stop_in_idle = (kind == 2);
          idle = 1'b1;
        end
      end
      if (kind != 0 && c == pa + pl_len) begin
        start = 1'b1;
        idle = 1'b0;
        stop_in_idle = 1'b0;
      end
      c++;
    end
    start = 1'b0;
    res = result;
    check(result == exp_res, bit_order ? "R6" : "R5", "remainder", result, exp_res);
    check(done_at == exp_dn, kind == 0 ? "R4" : (kind == 1 ? "R9" : "R10"),
          "finish edge", 32'(done_at), 32'(exp_dn));
    check(irq_at == exp_ir, irq_sel ? "R7" : "R8", "irq edge", 32'(irq_at), 32'(exp_ir));
  endtask

  initial begin
    #(1_500_000);
    total++;
    bad++;
    $display("FAIL watchdog R4 actual=running expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [31:0] r;
    rst_n = 1'b0; enable = 1'b0; start = 1'b0; stop_in_idle = 1'b0; idle = 1'b0;
    seed_load = 1'b0; wr_valid = 1'b0; wr_data = '0;
    cfg(7, 7, 1'b0, 1'b0, 32'h07, 32'h0);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    // R1 reset state
    check(word_count == 0 && fifo_empty && !fifo_full, "R1", "queue after reset",
          {27'b0, word_count}, 32'h0);
    check(!irq && !result_valid && result == 0, "R1", "outputs after reset", result, 32'h0);
    enable = 1'b1;
    @(negedge clk);

    // Sweep of polynomial lengths, word lengths, bit orders and irq points.
    for (int p = 0; p < 32; p++) begin
      for (int di = 0; di < 4; di++) begin
        for (int o = 0; o < 2; o++) begin
          int dl = (di == 0) ? 0 : (di == 1) ? 7 : (di == 2) ? 12 : 31;
          cfg(p, dl, o[0], 1'((p + di + o) % 2), next_rnd() | 32'h1, next_rnd());
          load_seed();
          for (int k = 0; k < 3; k++) begin
            job[k] = next_rnd();
            push(job[k]);
          end
          go(3, -1, 0, 0, r);
        end
      end
    end

    // R5 known 8-bit check value over ASCII "123456789"
    cfg(7, 7, 1'b0, 1'b0, 32'h07, 32'h0);
    load_seed();
    for (int i = 0; i < 9; i++) begin
      job[i] = 32'h31 + 32'(i);
      push(job[i]);
    end
    go(9, -1, 0, 0, r);
    check(r == 32'hF4, "R5", "8-bit check value", r, 32'hF4);

    // R5 known 16-bit check value; ninth byte arrives mid-run (capacity 8)
    cfg(15, 7, 1'b0, 1'b0, 32'h1021, 32'h0);
    load_seed();
    for (int i = 0; i < 8; i++) push(32'h31 + 32'(i));
    start = 1'b1;
    repeat (3) @(negedge clk);
    push(32'h39);
    for (int i = 0; i < 200 && !result_valid; i++) @(negedge clk);
    start = 1'b0;
    check(result_valid && result == 32'h31C3, "R5", "16-bit check value", result, 32'h31C3);

    // R6 bit order on a single word 0x01, 8-bit polynomial 0x07
    cfg(7, 7, 1'b1, 1'b0, 32'h07, 32'h0);
    load_seed();
    job[0] = 32'hFFFF_FF01;
    push(job[0]);
    go(1, -1, 0, 0, r);
    check(r == 32'h89, "R6", "low bit first", r, 32'h89);
    cfg(7, 7, 1'b0, 1'b0, 32'h07, 32'h0);
    load_seed();
    push(job[0]);
    go(1, -1, 0, 0, r);
    check(r == 32'h07, "R6", "top bit first", r, 32'h07);

    // R11 hold, then a write clears result_valid
    repeat (5) @(negedge clk);
    check(result_valid && result == 32'h07, "R11", "result held", result, 32'h07);
    push(32'h5);
    check(!result_valid, "R11", "write clears valid", {31'b0, result_valid}, 32'h0);

    // R9, R10 halts and pass-through
    for (int kind = 1; kind < 4; kind++) begin
      cfg(11, 7, 1'b0, 1'b1, 32'h80F, 32'hABC);
      enable = 1'b0;
      @(negedge clk);
      enable = 1'b1;
      load_seed();
      for (int k = 0; k < 2; k++) begin
        job[k] = next_rnd();
        push(job[k]);
      end
      go(2, 3, 10, kind, r);
    end

    // R2, R3 capacity 16 for short polynomials, extra write dropped
    enable = 1'b0;
    @(negedge clk);
    enable = 1'b1;
    cfg(7, 7, 1'b0, 1'b0, 32'h07, 32'h0);
    for (int i = 0; i < 17; i++) push(32'(i));
    check(word_count == 16 && fifo_full && !fifo_empty, "R3", "capacity 16",
          {27'b0, word_count}, 32'd16);
    enable = 1'b0;
    @(negedge clk);
    // R1 disable clears
    check(word_count == 0 && fifo_empty && !fifo_full && !irq && !result_valid && result == 0,
          "R1", "disable clears", {27'b0, word_count}, 32'h0);
    enable = 1'b1;
    cfg(20, 15, 1'b1, 1'b0, 32'h1A2B3C5, 32'h55AA);
    load_seed();
    for (int i = 0; i < 9; i++) begin
      job[i] = next_rnd();
      push(job[i]);
    end
    check(word_count == 8 && fifo_full, "R3", "capacity 8", {27'b0, word_count}, 32'd8);
    check(!fifo_empty, "R2", "not empty", {31'b0, fifo_empty}, 32'h0);
    go(8, -1, 0, 0, r);
    check(fifo_empty && word_count == 0, "R2", "empty after run", {27'b0, word_count}, 32'h0);

    // R1 disable in the middle of a run
    load_seed();
    for (int i = 0; i < 3; i++) push(next_rnd());
    start = 1'b1;
    repeat (4) @(negedge clk);
    enable = 1'b0;
    @(negedge clk);
    start = 1'b0;
    check(word_count == 0 && fifo_empty && !result_valid && result == 0 && !irq,
          "R1", "disable mid-run", result, 32'h0);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule